// File: doc/BRIEF.md
# Byte Command Decoder with GPIO Banks

This block sits between a host receive FIFO, which supplies a stream of command bytes, and a host transmit FIFO, which takes response bytes back. It reads one opcode at a time, gathers the argument bytes that opcode needs, and then acts on it. Transfer commands are not executed here. The block passes each one to a serial shift engine as a descriptor holding the flags and the length, and then forwards any outbound payload bytes on a separate byte port.

Pin-control commands are carried out inside the block. It owns a low and a high GPIO bank, and each bank has an output value register and a direction register. The block also holds an internal loopback enable and a 16-bit clock divisor that it presents to the shift engine. It can stall the command stream until a chosen low-bank pin reaches a given level, and it can tell the transmit FIFO to push its contents to the host at once. Pin inputs pass through a synchronizer before they are read or waited on.

Top module: `byte_cmd_decoder`

## Requirements
- R1: After reset, every GPIO direction bit is 0 (input), loopback is off, the divisor is 0, no response or descriptor is offered, and the block is ready to accept an opcode.
- R2: Opcode 0x80 is followed by two bytes. The first byte is loaded into the low-bank output value and the second into the low-bank direction. A direction bit of 1 makes that pin drive its value bit.
- R3: Opcode 0x82 is followed by a value byte and then a direction byte, and loads them into the high bank in the same way.
- R4: Opcodes 0x81 (low bank) and 0x83 (high bank) each send exactly one byte to the host. That byte holds the synchronized input levels of the bank's pins.
- R5: Opcode 0x84 sets the loopback output to 1, and opcode 0x85 clears it.
- R6: Opcode 0x86 is followed by two bytes, least significant first. Together they form the 16-bit divisor output.
- R7: Opcode 0x87 raises the flush output for one cycle. This happens only after every earlier response byte has been taken by the transmit FIFO.
- R8: An opcode with bit 7 clear and bit 1 clear is a byte-count transfer. The next two bytes are the length, least significant first. The descriptor carries flags = opcode[6:0] and this length, and is held until it is accepted. If bit 4 is set, length+1 payload bytes follow and are forwarded on the payload port.
- R9: An opcode with bit 7 clear and bit 1 set is a bit-count transfer. It has a single length byte, which becomes the descriptor length. If bit 4 is set, exactly one payload byte follows.
- R10: When bit 4 of a transfer opcode is clear, nothing is forwarded on the payload port. The byte after the length is decoded as the next opcode.
- R11: Opcode 0x88 (0x89) stops all further byte intake until synchronized low-bank pin 1 reads 1 (0).
- R12: Any opcode from 0x8A to 0xFF sends two bytes to the host: 0xFA and then the opcode itself. Decoding then resumes with the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Command byte from the host receive FIFO |
| rx_valid | input | 1 | rx_data holds a byte |
| rx_ready | output | 1 | Byte on rx_data is consumed this cycle |
| tx_data | output | 8 | Response byte to the transmit FIFO |
| tx_valid | output | 1 | tx_data holds a response byte |
| tx_ready | input | 1 | Transmit FIFO takes tx_data |
| tx_flush | output | 1 | One-cycle request to push pending bytes to the host |
| xfer_valid | output | 1 | Transfer descriptor offered |
| xfer_ready | input | 1 | Shift engine takes the descriptor |
| xfer_flags | output | 7 | Transfer opcode bits 6..0 |
| xfer_len | output | 16 | Transfer length field |
| pay_data | output | 8 | Outbound payload byte |
| pay_valid | output | 1 | pay_data holds a payload byte |
| pay_ready | input | 1 | Shift engine takes the payload byte |
| loopback_en | output | 1 | Internal serial loopback enable |
| clk_div | output | 16 | Serial clock divisor |
| gpio_lo_in | input | 8 | Low-bank pin levels |
| gpio_lo_out | output | 8 | Low-bank output values |
| gpio_lo_oe | output | 8 | Low-bank drive enables |
| gpio_hi_in | input | 8 | High-bank pin levels |
| gpio_hi_out | output | 8 | High-bank output values |
| gpio_hi_oe | output | 8 | High-bank drive enables |

## Verification
The assertions assume that the transmit FIFO, the shift engine and the host keep to valid/ready rules. A producer holds its byte steady until that byte is taken, and a consumer may stall for any length of time. They also assume that pin levels change slowly compared with the synchronizer depth. The bench drives each receive byte and keeps it stable until rx_ready takes it. It stalls tx_ready, xfer_ready and pay_ready in fixed repeating patterns. It models the pads so that a pin reads its output value where drive is enabled and an external level elsewhere. External levels change only while the block is idle or waiting, and the bench lets several cycles pass before any read that depends on them.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int BYTE_W = 8;
   localparam int LEN_W  = 2 * BYTE_W;
   localparam int FLAG_W = BYTE_W - 1;

   // flag bit positions inside a transfer opcode
   localparam int FLAG_BITS = 1;
   localparam int FLAG_DOUT = 4;

   localparam logic [BYTE_W-1:0] OP_SET_LO  = 8'h80;
   localparam logic [BYTE_W-1:0] OP_GET_LO  = 8'h81;
   localparam logic [BYTE_W-1:0] OP_SET_HI  = 8'h82;
   localparam logic [BYTE_W-1:0] OP_GET_HI  = 8'h83;
   localparam logic [BYTE_W-1:0] OP_LB_ON   = 8'h84;
   localparam logic [BYTE_W-1:0] OP_LB_OFF  = 8'h85;
   localparam logic [BYTE_W-1:0] OP_DIV     = 8'h86;
   localparam logic [BYTE_W-1:0] OP_PUSH    = 8'h87;
   localparam logic [BYTE_W-1:0] OP_WAIT_HI = 8'h88;
   localparam logic [BYTE_W-1:0] OP_WAIT_LO = 8'h89;

   typedef enum logic [2:0] {
      ST_OP   = 3'd0,
      ST_ARG  = 3'd1,
      ST_DESC = 3'd2,
      ST_PAY  = 3'd3,
      ST_WAIT = 3'd4
   } dec_state_e;

   function automatic logic op_known(input logic [BYTE_W-1:0] op);
      return (op >= OP_SET_LO) && (op <= OP_WAIT_LO);
   endfunction
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("bcd_sync: W must be at least 1");
      end
      if (STAGES < 0) begin : g_bad_stages
         $error("bcd_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_thru
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bcd_gpio_bank.sv
module bcd_gpio_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   input  logic [W-1:0] wr_dir,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);
   generate
      if (W < 1) begin : g_bad_w
         $error("bcd_gpio_bank: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= '0;
         pin_oe  <= '0;
      end else if (wr_en) begin
         pin_out <= wr_val;
         pin_oe  <= wr_dir;
      end
   end

   // drive enables move only as the result of a bank write (R2, R3)
   p_dir_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe) |-> $past(wr_en));
endmodule

// File: rtl/bcd_resp.sv
module bcd_resp #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_one,
   input  logic         ld_two,
   input  logic [W-1:0] b0,
   input  logic [W-1:0] b1,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic         busy
);
   logic [W-1:0] q0, q1;
   logic [1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q0  <= '0;
         q1  <= '0;
         cnt <= 2'd0;
      end else if (ld_two) begin
         q0  <= b0;
         q1  <= b1;
         cnt <= 2'd2;
      end else if (ld_one) begin
         q0  <= b0;
         cnt <= 2'd1;
      end else if (out_valid && out_ready) begin
         q0  <= q1;
         cnt <= cnt - 2'd1;
      end
   end

   assign out_valid = (cnt != 2'd0);
   assign out_data  = q0;
   assign busy      = out_valid;

   // a response byte stays put until the transmit FIFO takes it (R4)
   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // a new response is only loaded once the previous one is gone (R12)
   p_load_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_one || ld_two) |-> !out_valid);
endmodule

// File: rtl/byte_cmd_decoder.sv
module byte_cmd_decoder
   import bcd_pkg::*;
#(
   parameter int              GPIO_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter int              WAIT_PIN    = 1,
   parameter logic [BYTE_W-1:0] BAD_MARK  = 8'hFA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_flush,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [FLAG_W-1:0] xfer_flags,
   output logic [LEN_W-1:0]  xfer_len,
   output logic [BYTE_W-1:0] pay_data,
   output logic              pay_valid,
   input  logic              pay_ready,
   output logic              loopback_en,
   output logic [LEN_W-1:0]  clk_div,
   input  logic [GPIO_W-1:0] gpio_lo_in,
   output logic [GPIO_W-1:0] gpio_lo_out,
   output logic [GPIO_W-1:0] gpio_lo_oe,
   input  logic [GPIO_W-1:0] gpio_hi_in,
   output logic [GPIO_W-1:0] gpio_hi_out,
   output logic [GPIO_W-1:0] gpio_hi_oe
);
   localparam int NBANK = 2;
   localparam int CNT_W = LEN_W + 1;

   generate
      if (GPIO_W < 2 || GPIO_W > BYTE_W) begin : g_bad_gpio
         $error("byte_cmd_decoder: GPIO_W must lie in 2..8");
      end
      if (WAIT_PIN < 0 || WAIT_PIN >= GPIO_W) begin : g_bad_wait
         $error("byte_cmd_decoder: WAIT_PIN outside the low bank");
      end
   endgenerate

   dec_state_e        state;
   logic [BYTE_W-1:0] op_q;
   logic              arg_two;
   logic              arg_idx;
   logic [BYTE_W-1:0] arg0;
   logic [LEN_W-1:0]  len_q;
   logic [CNT_W-1:0]  pay_cnt;
   logic              wait_lvl;
   logic              loop_q;
   logic [LEN_W-1:0]  div_q;
   logic              flush_q;

   logic              rx_take;
   logic              arg_last;
   logic [BYTE_W-1:0] arg_lsb, arg_msb;
   logic              resp_busy;
   logic              ld_one, ld_two;
   logic [BYTE_W-1:0] resp_b0, resp_b1;

   logic [NBANK-1:0][GPIO_W-1:0] pin_raw, pin_sync, bank_out, bank_oe;
   logic [NBANK-1:0]             bank_wr;

   // ---------------- GPIO banks ----------------
   assign pin_raw[0] = gpio_lo_in;
   assign pin_raw[1] = gpio_hi_in;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         localparam logic [BYTE_W-1:0] SET_OP = OP_SET_LO + BYTE_W'(2 * b);

         bcd_sync #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[b]),
            .q     (pin_sync[b])
         );

         assign bank_wr[b] = arg_last && (op_q == SET_OP);

         bcd_gpio_bank #(.W(GPIO_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[b]),
            .wr_val  (arg_lsb[GPIO_W-1:0]),
            .wr_dir  (arg_msb[GPIO_W-1:0]),
            .pin_out (bank_out[b]),
            .pin_oe  (bank_oe[b])
         );
      end
   endgenerate

   assign gpio_lo_out = bank_out[0];
   assign gpio_lo_oe  = bank_oe[0];
   assign gpio_hi_out = bank_out[1];
   assign gpio_hi_oe  = bank_oe[1];

   // ---------------- byte intake ----------------
   always_comb begin
      case (state)
         ST_OP:   rx_ready = !resp_busy;
         ST_ARG:  rx_ready = 1'b1;
         ST_PAY:  rx_ready = pay_ready;
         default: rx_ready = 1'b0;
      endcase
   end

   assign rx_take  = rx_valid && rx_ready;
   assign arg_last = (state == ST_ARG) && rx_take && (arg_idx || !arg_two);
   assign arg_lsb  = arg_two ? arg0    : rx_data;
   assign arg_msb  = arg_two ? rx_data : '0;

   // ---------------- response selection ----------------
   always_comb begin
      ld_one  = 1'b0;
      ld_two  = 1'b0;
      resp_b0 = BAD_MARK;
      resp_b1 = rx_data;
      if (state == ST_OP && rx_take && rx_data[BYTE_W-1]) begin
         if (!op_known(rx_data)) begin
            ld_two = 1'b1;
         end
         for (int b = 0; b < NBANK; b++) begin
            if (rx_data == OP_GET_LO + BYTE_W'(2 * b)) begin
               ld_one  = 1'b1;
               resp_b0 = '0;
               resp_b0[GPIO_W-1:0] = pin_sync[b];
            end
         end
      end
   end

   bcd_resp #(.W(BYTE_W)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_one    (ld_one),
      .ld_two    (ld_two),
      .b0        (resp_b0),
      .b1        (resp_b1),
      .out_data  (tx_data),
      .out_valid (tx_valid),
      .out_ready (tx_ready),
      .busy      (resp_busy)
   );

   // ---------------- decode sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_OP;
         op_q     <= '0;
         arg_two  <= 1'b0;
         arg_idx  <= 1'b0;
         arg0     <= '0;
         len_q    <= '0;
         pay_cnt  <= '0;
         wait_lvl <= 1'b0;
         loop_q   <= 1'b0;
         div_q    <= '0;
         flush_q  <= 1'b0;
      end else begin
         flush_q <= 1'b0;
         case (state)
            ST_OP: begin
               if (rx_take) begin
                  if (!rx_data[BYTE_W-1]) begin
                     op_q    <= rx_data;
                     arg_two <= !rx_data[FLAG_BITS];
                     arg_idx <= 1'b0;
                     state   <= ST_ARG;
                  end else begin
                     case (rx_data)
                        OP_SET_LO, OP_SET_HI, OP_DIV: begin
                           op_q    <= rx_data;
                           arg_two <= 1'b1;
                           arg_idx <= 1'b0;
                           state   <= ST_ARG;
                        end
                        OP_LB_ON:  loop_q  <= 1'b1;
                        OP_LB_OFF: loop_q  <= 1'b0;
                        OP_PUSH:   flush_q <= 1'b1;
                        OP_WAIT_HI, OP_WAIT_LO: begin
                           wait_lvl <= (rx_data == OP_WAIT_HI);
                           state    <= ST_WAIT;
                        end
                        default: ;
                     endcase
                  end
               end
            end
            ST_ARG: begin
               if (rx_take) begin
                  if (!arg_last) begin
                     arg0    <= rx_data;
                     arg_idx <= 1'b1;
                  end else if (op_q == OP_DIV) begin
                     div_q <= {arg_msb, arg_lsb};
                     state <= ST_OP;
                  end else if (op_q[BYTE_W-1]) begin
                     state <= ST_OP;
                  end else begin
                     len_q <= {arg_msb, arg_lsb};
                     state <= ST_DESC;
                  end
               end
            end
            ST_DESC: begin
               if (xfer_ready) begin
                  if (op_q[FLAG_DOUT]) begin
                     pay_cnt <= op_q[FLAG_BITS] ? CNT_W'(1)
                                                : CNT_W'(len_q) + CNT_W'(1);
                     state   <= ST_PAY;
                  end else begin
                     state <= ST_OP;
                  end
               end
            end
            ST_PAY: begin
               if (rx_take) begin
                  pay_cnt <= pay_cnt - CNT_W'(1);
                  if (pay_cnt == CNT_W'(1)) state <= ST_OP;
               end
            end
            ST_WAIT: begin
               if (pin_sync[0][WAIT_PIN] == wait_lvl) state <= ST_OP;
            end
            default: state <= ST_OP;
         endcase
      end
   end

   assign xfer_valid  = (state == ST_DESC);
   assign xfer_flags  = op_q[FLAG_W-1:0];
   assign xfer_len    = len_q;
   assign pay_valid   = (state == ST_PAY) && rx_valid;
   assign pay_data    = rx_data;
   assign loopback_en = loop_q;
   assign clk_div     = div_q;
   assign tx_flush    = flush_q;

   // ---------------- assertions ----------------
   // no new byte is pulled while a response is still waiting (R12)
   p_resp_before_intake_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> !tx_valid);

   // a flush request never overtakes a pending response byte (R7)
   p_flush_after_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |-> !tx_valid);

   // descriptor held steady until accepted (R8)
   p_desc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_len) && $stable(xfer_flags));

   // payload never overlaps an unaccepted descriptor (R10)
   p_pay_after_desc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> !xfer_valid);

   // divisor changes only as an argument is consumed (R6)
   p_div_from_args_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_div) |-> $past(state == ST_ARG && rx_take));
endmodule

// File: tb/byte_cmd_decoder_test.sv
module byte_cmd_decoder_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [7:0]  rx_data = 8'h00;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_ready, tx_flush;
   logic        xfer_valid, xfer_ready;
   logic [6:0]  xfer_flags;
   logic [15:0] xfer_len;
   logic [7:0]  pay_data;
   logic        pay_valid, pay_ready;
   logic        loopback_en;
   logic [15:0] clk_div;
   logic [7:0]  gpio_lo_in, gpio_lo_out, gpio_lo_oe;
   logic [7:0]  gpio_hi_in, gpio_hi_out, gpio_hi_oe;
   logic [7:0]  ext_lo = 8'hC4;
   logic [7:0]  ext_hi = 8'h3C;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;
   assign tx_ready   = (cyc % 4) != 1;
   assign pay_ready  = (cyc % 3) != 0;
   assign xfer_ready = (cyc % 5) == 0;

   assign gpio_lo_in = (gpio_lo_oe & gpio_lo_out) | (~gpio_lo_oe & ext_lo);
   assign gpio_hi_in = (gpio_hi_oe & gpio_hi_out) | (~gpio_hi_oe & ext_hi);

   byte_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flush(tx_flush),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
      .xfer_flags(xfer_flags), .xfer_len(xfer_len),
      .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
      .loopback_en(loopback_en), .clk_div(clk_div),
      .gpio_lo_in(gpio_lo_in), .gpio_lo_out(gpio_lo_out), .gpio_lo_oe(gpio_lo_oe),
      .gpio_hi_in(gpio_hi_in), .gpio_hi_out(gpio_hi_out), .gpio_hi_oe(gpio_hi_oe)
   );

   int total = 0;
   int bad = 0;
   int flushes = 0;
   logic [7:0]  exp_tx[$];
   logic [22:0] exp_desc[$];
   logic [7:0]  exp_pay[$];

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // scoreboard monitors
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (exp_tx.size() == 0) chk(1'b0, "R4/R12 unexpected tx byte", 32'(tx_data), 32'hFFFF);
         else begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            chk(tx_data == e, "R4/R12 tx byte", 32'(tx_data), 32'(e));
         end
      end
      if (rst_n && xfer_valid && xfer_ready) begin
         if (exp_desc.size() == 0) chk(1'b0, "R8/R9 unexpected descriptor", {9'd0, xfer_flags, xfer_len}, 32'hFFFF);
         else begin
            logic [22:0] e;
            e = exp_desc.pop_front();
            chk({xfer_flags, xfer_len} == e, "R8/R9 descriptor", {9'd0, xfer_flags, xfer_len}, 32'(e));
         end
      end
      if (rst_n && pay_valid && pay_ready) begin
         if (exp_pay.size() == 0) chk(1'b0, "R10 unexpected payload", 32'(pay_data), 32'hFFFF);
         else begin
            logic [7:0] e;
            e = exp_pay.pop_front();
            chk(pay_data == e, "R8/R9 payload", 32'(pay_data), 32'(e));
         end
      end
      if (rst_n && tx_flush) begin
         flushes++;
         chk(!tx_valid, "R7 flush with pending byte", 32'(tx_valid), 32'd0);
      end
   end

   task automatic send(input logic [7:0] b);
      @(posedge clk); #1;
      rx_data  = b;
      rx_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (rx_ready) break;
      end
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // hold a byte for n cycles and confirm it is never taken
   task automatic hold_blocked(input logic [7:0] b, input int n, input string tag);
      logic taken;
      taken = 1'b0;
      @(posedge clk); #1;
      rx_data  = b;
      rx_valid = 1'b1;
      repeat (n) begin
         @(negedge clk);
         if (rx_ready) taken = 1'b1;
      end
      chk(!taken, tag, 32'(taken), 32'd0);
   endtask

   task automatic release_held();
      forever begin
         @(negedge clk);
         if (rx_ready) break;
      end
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic run_all();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle(1);
      // R1 reset state
      chk(gpio_lo_oe == 8'h00 && gpio_hi_oe == 8'h00, "R1 directions", {gpio_hi_oe, gpio_lo_oe}, 32'd0);
      chk(loopback_en == 1'b0 && clk_div == 16'h0, "R1 loopback/divisor", {loopback_en, clk_div}, 32'd0);
      chk(!tx_valid && !xfer_valid && rx_ready, "R1 handshakes", {tx_valid, xfer_valid, rx_ready}, 32'd1);

      // R2 low bank set, R4 readback
      send(8'h80); send(8'hA5); send(8'h0F);
      settle(2);
      chk(gpio_lo_out == 8'hA5 && gpio_lo_oe == 8'h0F, "R2 low bank", {gpio_lo_out, gpio_lo_oe}, 32'hA50F);
      settle(4);
      exp_tx.push_back(8'hC5);
      send(8'h81);

      // R3 high bank set, R4 readback
      send(8'h82); send(8'h5A); send(8'hF0);
      settle(2);
      chk(gpio_hi_out == 8'h5A && gpio_hi_oe == 8'hF0, "R3 high bank", {gpio_hi_out, gpio_hi_oe}, 32'h5AF0);
      settle(4);
      exp_tx.push_back(8'h5C);
      send(8'h83);

      // R5 loopback
      send(8'h84); settle(1);
      chk(loopback_en == 1'b1, "R5 loopback on", 32'(loopback_en), 32'd1);
      send(8'h85); settle(1);
      chk(loopback_en == 1'b0, "R5 loopback off", 32'(loopback_en), 32'd0);

      // R6 divisor
      send(8'h86); send(8'h34); send(8'h12); settle(1);
      chk(clk_div == 16'h1234, "R6 divisor", 32'(clk_div), 32'h1234);

      // R7 flush after a pending read
      exp_tx.push_back(8'hC5);
      send(8'h81);
      send(8'h87);
      settle(3);
      chk(flushes == 1, "R7 flush count", 32'(flushes), 32'd1);

      // R8 byte-count out transfer with 3 payload bytes
      exp_desc.push_back({7'h11, 16'h0002});
      exp_pay.push_back(8'hAA); exp_pay.push_back(8'hBB); exp_pay.push_back(8'hCC);
      send(8'h11); send(8'h02); send(8'h00);
      send(8'hAA); send(8'hBB); send(8'hCC);

      // R9 bit-count out transfer with one payload byte
      exp_desc.push_back({7'h13, 16'h0005});
      exp_pay.push_back(8'h5A);
      send(8'h13); send(8'h05); send(8'h5A);

      // R10 input-only byte transfer: next byte is an opcode
      exp_desc.push_back({7'h20, 16'h0103});
      send(8'h20); send(8'h03); send(8'h01);
      exp_tx.push_back(8'hC5);
      send(8'h81);

      // R9/R10 input-only bit transfer
      exp_desc.push_back({7'h22, 16'h0007});
      send(8'h22); send(8'h07);

      // R12 unrecognised opcodes then normal decode
      exp_tx.push_back(8'hFA); exp_tx.push_back(8'h8A);
      send(8'h8A);
      exp_tx.push_back(8'hFA); exp_tx.push_back(8'hFF);
      send(8'hFF);
      exp_tx.push_back(8'h5C);
      send(8'h83);

      // R11 wait for pin 1 high, then low
      send(8'h80); send(8'h00); send(8'h00);
      settle(6);
      send(8'h88);
      exp_tx.push_back(8'hC6);
      hold_blocked(8'h81, 20, "R11 wait-high blocks intake");
      ext_lo = 8'hC6;
      release_held();
      settle(6);
      send(8'h89);
      exp_tx.push_back(8'hC4);
      hold_blocked(8'h81, 20, "R11 wait-low blocks intake");
      ext_lo = 8'hC4;
      release_held();

      // drain
      for (int i = 0; i < 2000; i++) begin
         if (exp_tx.size() == 0 && exp_desc.size() == 0 && exp_pay.size() == 0) break;
         @(negedge clk);
      end
      settle(4);
      chk(exp_tx.size() == 0, "R4/R12 tx drained", 32'(exp_tx.size()), 32'd0);
      chk(exp_desc.size() == 0, "R8/R9 descriptors drained", 32'(exp_desc.size()), 32'd0);
      chk(exp_pay.size() == 0, "R8/R9 payload drained", 32'(exp_pay.size()), 32'd0);
      chk(flushes == 1, "R7 single flush", 32'(flushes), 32'd1);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            chk(1'b0, "watchdog expired", 32'd0, 32'd1);
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule